// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds a set of 64-bit control and status registers and gives two independent requesters access to them. One requester is a scan-style configuration port. The other is a memory-mapped port. Each port has its own valid/ready handshake, a write strobe, a byte address and write data. Each port also has a registered read response. The two ports turn byte addresses into register indices differently. The configuration port drops the three low address bits. The memory-mapped port does the same and then adds a fixed offset of ten, wrapping modulo the index space.

The bank contains:
- a fault register that can be overwritten, ANDed or ORed through three separate indices;
- a control register that can be overwritten, bit-set or bit-cleared;
- a base-address register that only the configuration port may change;
- a masked secondary base register;
- a read-only interrupt status register;
- four plain read/write registers.

Two kinds of write are refused and produce a one-cycle error pulse: a memory-mapped write to the base register, and any write to the status register. A separate one-cycle pulse reports every change of the control register's memory-enable bit, so a neighbouring address decoder can react to it.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every register reads zero, except the base register at index 0x0A, which reads the BASE_RESET parameter with bit 0 (enable) set. All response, error and pulse outputs are low.
- R2: The configuration port accesses index addr>>3. The memory-mapped port accesses index ((addr>>3)+0x0A) mod 256. For example, memory-mapped byte address 0x20 reaches the control register at index 0x0E.
- R3: The fault register sits at index 0x00. A write to index 0x01 replaces it with (fault AND data). A write to index 0x02 replaces it with (fault OR data).
- R4: The control register sits at index 0x0E. A write to index 0x12 ORs the data into it. A write to index 0x13 clears every bit that is set in the data.
- R5: A memory-mapped write to the base register (index 0x0A) leaves it unchanged, and access_err is high in the cycle after the accepted write. A configuration write to the base register is accepted.
- R6: The base register stores data AND (0x0003_FFFF_FFF0_0000 OR 0x1). The secondary base register at index 0x0B stores data AND 0x0003_FFFF_0000_0000.
- R7: The readable indices are 0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x14 and 0x15. A read of any other index returns all ones, including the write-only alias indices. A write to an index with no register has no effect.
- R8: The status register at index 0x15 reads zero and cannot be written. A write to it from either port pulses access_err in the next cycle.
- R9: cfg_ready is always high. mm_ready is low in any cycle where cfg_valid is high, so at most one access is taken per cycle, and the configuration port wins.
- R10: mem_en_toggle is high for exactly the cycle after an accepted write changes bit 62 of the control register.
- R11: An accepted read raises that port's rvalid in the next cycle, with the register value in its rdata. rdata holds its value until the next read.
- R12: An access whose byte address has a nonzero value in bits [2:0] is not a full 64-bit access. As a read it returns all ones. As a write it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Configuration request accepted |
| cfg_write | input | 1 | 1 = write, 0 = read (configuration) |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rvalid | output | 1 | Configuration read response valid |
| cfg_rdata | output | 64 | Configuration read data |
| mm_valid | input | 1 | Memory-mapped request valid |
| mm_ready | output | 1 | Memory-mapped request accepted |
| mm_write | input | 1 | 1 = write, 0 = read (memory-mapped) |
| mm_addr | input | ADDR_W | Memory-mapped byte address |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read response valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| access_err | output | 1 | One-cycle pulse for a refused write |
| mem_en_toggle | output | 1 | One-cycle pulse when control bit 62 changes |

## Verification
The functions that collide in one cycle are the two ports' requests. A configuration read and a memory-mapped write are presented in the same cycle, and the memory-mapped request is held until it is taken. The bench judges the outcome on three points: mm_ready must stay low during the overlap, the configuration read must complete first, and the memory-mapped write must land one cycle later. A behavioural model checks every cycle that no second access slipped through. Alias writes that also flip the memory-enable bit stack a toggle pulse onto an alias update in the same cycle. Refused base writes are compared against unchanged read-back values.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned IDX_W  = 8;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    // register indices (alias indices are decoded by position)
    localparam idx_t IX_FAULT     = 8'h00;
    localparam idx_t IX_FAULT_AND = 8'h01;
    localparam idx_t IX_FAULT_OR  = 8'h02;
    localparam idx_t IX_ACT0      = 8'h06;
    localparam idx_t IX_ACT1      = 8'h07;
    localparam idx_t IX_BASE      = 8'h0A;
    localparam idx_t IX_BASE2     = 8'h0B;
    localparam idx_t IX_CTRL      = 8'h0E;
    localparam idx_t IX_EMASK     = 8'h0F;
    localparam idx_t IX_CTRL_SET  = 8'h12;
    localparam idx_t IX_CTRL_CLR  = 8'h13;
    localparam idx_t IX_DMA       = 8'h14;
    localparam idx_t IX_STAT      = 8'h15;

    localparam int unsigned MM_OFFSET  = 10;
    localparam int unsigned MEM_EN_BIT = 62;

    localparam word_t BASE_MASK  = 64'h0003_FFFF_FFF0_0000;
    localparam word_t BASE2_MASK = 64'h0003_FFFF_0000_0000;
    localparam word_t ENABLE_BIT = 64'h0000_0000_0000_0001;
    localparam word_t ALL_ONES   = {DATA_W{1'b1}};

    typedef struct packed {
        word_t fault;
        word_t act0;
        word_t act1;
        word_t base;
        word_t base2;
        word_t ctrl;
        word_t emask;
        word_t dma;
        word_t stat;
    } bank_t;

    typedef struct packed {
        logic  fire;
        logic  from_mm;
        logic  write;
        logic  aligned;
        idx_t  idx;
        word_t data;
    } req_t;

endpackage

// File: rtl/crb_xlate.sv
module crb_xlate
    import crb_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned OFFSET = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output idx_t              idx,
    output logic              aligned
);
    localparam int unsigned LANE_BITS = $clog2(DATA_W / 8);

    idx_t word_idx;

    assign word_idx = IDX_W'(addr[ADDR_W-1:LANE_BITS]);
    assign aligned  = (addr[LANE_BITS-1:0] == '0);

    generate
        if (OFFSET == 0) begin : g_direct
            assign idx = word_idx;
        end else begin : g_offset
            assign idx = word_idx + IDX_W'(OFFSET);
        end
    endgenerate

endmodule

// File: rtl/crb_arb.sv
module crb_arb
    import crb_pkg::*;
(
    input  logic  cfg_valid,
    input  logic  cfg_write,
    input  idx_t  cfg_idx,
    input  logic  cfg_aligned,
    input  word_t cfg_wdata,
    input  logic  mm_valid,
    input  logic  mm_write,
    input  idx_t  mm_idx,
    input  logic  mm_aligned,
    input  word_t mm_wdata,
    output logic  cfg_ready,
    output logic  mm_ready,
    output req_t  req
);
    assign cfg_ready = 1'b1;
    assign mm_ready  = !cfg_valid;

    always_comb begin
        req = '0;
        if (cfg_valid) begin
            req.fire    = 1'b1;
            req.from_mm = 1'b0;
            req.write   = cfg_write;
            req.aligned = cfg_aligned;
            req.idx     = cfg_idx;
            req.data    = cfg_wdata;
        end else if (mm_valid) begin
            req.fire    = 1'b1;
            req.from_mm = 1'b1;
            req.write   = mm_write;
            req.aligned = mm_aligned;
            req.idx     = mm_idx;
            req.data    = mm_wdata;
        end
    end

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import crb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter logic [63:0] BASE_RESET = 64'h0003_FFFE_8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_rvalid,
    output logic [63:0]       cfg_rdata,
    input  logic              mm_valid,
    output logic              mm_ready,
    input  logic              mm_write,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [63:0]       mm_wdata,
    output logic              mm_rvalid,
    output logic [63:0]       mm_rdata,
    output logic              access_err,
    output logic              mem_en_toggle
);
    localparam word_t BASE_KEEP  = BASE_MASK | ENABLE_BIT;
    localparam word_t BASE_START = (BASE_RESET & BASE_MASK) | ENABLE_BIT;

    typedef struct packed {
        bank_t bank;
        word_t rdata;
        logic  cfg_rv;
        logic  mm_rv;
        logic  err;
        logic  tog;
    } state_t;

    state_t s_d, s_q;
    idx_t   cfg_idx, mm_idx;
    logic   cfg_aligned, mm_aligned;
    req_t   req;

    crb_xlate #(.ADDR_W(ADDR_W), .OFFSET(0)) u_cfg_xlate (
        .addr(cfg_addr), .idx(cfg_idx), .aligned(cfg_aligned)
    );

    crb_xlate #(.ADDR_W(ADDR_W), .OFFSET(MM_OFFSET)) u_mm_xlate (
        .addr(mm_addr), .idx(mm_idx), .aligned(mm_aligned)
    );

    crb_arb u_arb (
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_idx(cfg_idx),
        .cfg_aligned(cfg_aligned), .cfg_wdata(cfg_wdata),
        .mm_valid(mm_valid), .mm_write(mm_write), .mm_idx(mm_idx),
        .mm_aligned(mm_aligned), .mm_wdata(mm_wdata),
        .cfg_ready(cfg_ready), .mm_ready(mm_ready), .req(req)
    );

    function automatic word_t bank_read(idx_t i, bank_t b);
        word_t v;
        case (i)
            IX_FAULT: v = b.fault;
            IX_ACT0:  v = b.act0;
            IX_ACT1:  v = b.act1;
            IX_BASE:  v = b.base;
            IX_BASE2: v = b.base2;
            IX_CTRL:  v = b.ctrl;
            IX_EMASK: v = b.emask;
            IX_DMA:   v = b.dma;
            IX_STAT:  v = b.stat;
            default:  v = ALL_ONES;
        endcase
        return v;
    endfunction

    always_comb begin
        s_d        = s_q;
        s_d.cfg_rv = 1'b0;
        s_d.mm_rv  = 1'b0;
        s_d.err    = 1'b0;
        if (req.fire && !req.write) begin
            s_d.rdata = req.aligned ? bank_read(req.idx, s_q.bank) : ALL_ONES;
            if (req.from_mm) s_d.mm_rv  = 1'b1;
            else             s_d.cfg_rv = 1'b1;
        end else if (req.fire && req.aligned) begin
            case (req.idx)
                IX_FAULT:     s_d.bank.fault = req.data;
                IX_FAULT_AND: s_d.bank.fault = s_q.bank.fault & req.data;
                IX_FAULT_OR:  s_d.bank.fault = s_q.bank.fault | req.data;
                IX_ACT0:      s_d.bank.act0  = req.data;
                IX_ACT1:      s_d.bank.act1  = req.data;
                IX_BASE: begin
                    if (req.from_mm) s_d.err       = 1'b1;
                    else             s_d.bank.base = req.data & BASE_KEEP;
                end
                IX_BASE2:     s_d.bank.base2 = req.data & BASE2_MASK;
                IX_CTRL:      s_d.bank.ctrl  = req.data;
                IX_CTRL_SET:  s_d.bank.ctrl  = s_q.bank.ctrl | req.data;
                IX_CTRL_CLR:  s_d.bank.ctrl  = s_q.bank.ctrl & ~req.data;
                IX_EMASK:     s_d.bank.emask = req.data;
                IX_DMA:       s_d.bank.dma   = req.data;
                IX_STAT:      s_d.err        = 1'b1;
                default:      ;
            endcase
        end
        s_d.tog = s_d.bank.ctrl[MEM_EN_BIT] ^ s_q.bank.ctrl[MEM_EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.bank.base <= BASE_START;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_rvalid    = s_q.cfg_rv;
    assign mm_rvalid     = s_q.mm_rv;
    assign cfg_rdata     = s_q.rdata;
    assign mm_rdata      = s_q.rdata;
    assign access_err    = s_q.err;
    assign mem_en_toggle = s_q.tog;

    // ---------------- assertions ----------------
    logic cfg_fire, mm_fire;
    assign cfg_fire = cfg_valid && cfg_ready;
    assign mm_fire  = mm_valid && mm_ready;

    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_fire && mm_fire));

    a_r9_cfg_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_ready);

    a_r5_mm_base_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_fire && mm_write && mm_aligned && mm_idx == IX_BASE)
        |=> ($stable(s_q.bank.base) && access_err));

    a_r6_base_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.bank.base & ~BASE_KEEP) == '0);

    a_r8_status_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (req.fire && req.write && req.aligned && req.idx == IX_STAT) |=> access_err);

    a_r10_toggle_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_toggle |-> (s_q.bank.ctrl[MEM_EN_BIT] != $past(s_q.bank.ctrl[MEM_EN_BIT])));

    a_r11_cfg_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fire && !cfg_write) |=> cfg_rvalid);

    a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_rvalid, mm_rvalid}));

endmodule

// File: tb/ctrl_reg_bank_test.sv
`timescale 1ns/100ps
module ctrl_reg_bank_test;
    localparam int unsigned ADDR_W = 11;
    localparam logic [63:0] BASE_RESET = 64'h0003_FFFE_8000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 0, cfg_write = 0, mm_valid = 0, mm_write = 0;
    logic [ADDR_W-1:0] cfg_addr = '0, mm_addr = '0;
    logic [63:0] cfg_wdata = '0, mm_wdata = '0;
    logic cfg_ready, mm_ready, cfg_rvalid, mm_rvalid, access_err, mem_en_toggle;
    logic [63:0] cfg_rdata, mm_rdata;

    ctrl_reg_bank #(.ADDR_W(ADDR_W), .BASE_RESET(BASE_RESET)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
        .cfg_rdata(cfg_rdata),
        .mm_valid(mm_valid), .mm_ready(mm_ready), .mm_write(mm_write),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rvalid(mm_rvalid),
        .mm_rdata(mm_rdata),
        .access_err(access_err), .mem_en_toggle(mem_en_toggle)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;

    // behavioural reference state
    logic [63:0] m_fault, m_act0, m_act1, m_base, m_base2, m_ctrl, m_emask, m_dma, m_stat;
    logic [63:0] m_rdata;
    bit m_cfg_rv, m_mm_rv, m_err, m_tog;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] m_read(int idx);
        case (idx)
            'h00: return m_fault;
            'h06: return m_act0;
            'h07: return m_act1;
            'h0A: return m_base;
            'h0B: return m_base2;
            'h0E: return m_ctrl;
            'h0F: return m_emask;
            'h14: return m_dma;
            'h15: return m_stat;
            default: return ONES;
        endcase
    endfunction

    task automatic m_apply(int idx, bit w, logic [63:0] d, bit mm, bit al);
        if (!w) begin
            m_rdata = al ? m_read(idx) : ONES;
            if (mm) m_mm_rv = 1; else m_cfg_rv = 1;
        end else if (al) begin
            case (idx)
                'h00: m_fault = d;
                'h01: m_fault = m_fault & d;
                'h02: m_fault = m_fault | d;
                'h06: m_act0 = d;
                'h07: m_act1 = d;
                'h0A: if (mm) m_err = 1; else m_base = d & 64'h0003_FFFF_FFF0_0001;
                'h0B: m_base2 = d & 64'h0003_FFFF_0000_0000;
                'h0E: m_ctrl = d;
                'h0F: m_emask = d;
                'h12: m_ctrl = m_ctrl | d;
                'h13: m_ctrl = m_ctrl & ~d;
                'h14: m_dma = d;
                'h15: m_err = 1;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fault = 0; m_act0 = 0; m_act1 = 0; m_base2 = 0; m_ctrl = 0;
            m_emask = 0; m_dma = 0; m_stat = 0; m_rdata = 0;
            m_base = BASE_RESET | 64'h1;
            m_cfg_rv = 0; m_mm_rv = 0; m_err = 0; m_tog = 0;
        end else begin
            bit old62;
            if (cmp_on) check("R9 mm_ready", {63'b0, mm_ready}, {63'b0, !cfg_valid});
            m_cfg_rv = 0; m_mm_rv = 0; m_err = 0;
            old62 = m_ctrl[62];
            if (cfg_valid)
                m_apply(int'(cfg_addr >> 3) & 255, cfg_write, cfg_wdata, 0, cfg_addr[2:0] == 0);
            else if (mm_valid)
                m_apply((int'(mm_addr >> 3) + 10) & 255, mm_write, mm_wdata, 1, mm_addr[2:0] == 0);
            m_tog = (old62 != m_ctrl[62]);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R11 cfg_rvalid", {63'b0, cfg_rvalid}, {63'b0, m_cfg_rv});
            check("R11 mm_rvalid", {63'b0, mm_rvalid}, {63'b0, m_mm_rv});
            check("R11 cfg_rdata", cfg_rdata, m_rdata);
            check("R11 mm_rdata", mm_rdata, m_rdata);
            check("R8 access_err", {63'b0, access_err}, {63'b0, m_err});
            check("R10 mem_en_toggle", {63'b0, mem_en_toggle}, {63'b0, m_tog});
        end
    end

    task automatic cfg_op(bit w, int a, logic [63:0] d);
        cfg_valid = 1; cfg_write = w; cfg_addr = ADDR_W'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic mm_op(bit w, int a, logic [63:0] d);
        mm_valid = 1; mm_write = w; mm_addr = ADDR_W'(a); mm_wdata = d;
        @(negedge clk);
        mm_valid = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during and right after reset
        check("R1 err in reset", {63'b0, access_err}, 64'h0);
        check("R1 rvalid in reset", {63'b0, cfg_rvalid | mm_rvalid}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        check("R1 toggle idle", {63'b0, mem_en_toggle}, 64'h0);
        cfg_op(0, 'h50, 0);
        check("R1 base reset", cfg_rdata, BASE_RESET | 64'h1);
        cfg_op(0, 'h70, 0);
        check("R1 ctrl reset", cfg_rdata, 64'h0);

        // R2 / R10: config write to ctrl, read via memory-mapped alias address
        cfg_op(1, 'h70, 64'h4000_0000_0000_00A5);
        check("R10 toggle on set", {63'b0, mem_en_toggle}, 64'h1);
        mm_op(0, 'h20, 0);
        check("R2 mm index offset", mm_rdata, 64'h4000_0000_0000_00A5);
        check("R11 mm_rvalid", {63'b0, mm_rvalid}, 64'h1);

        // R4: set alias via mm (index 0x12), clear alias via cfg (index 0x13)
        mm_op(1, 'h40, 64'h0F00);
        check("R10 no toggle", {63'b0, mem_en_toggle}, 64'h0);
        cfg_op(1, 'h98, 64'h4000_0000_0000_0005);
        check("R10 toggle on clear", {63'b0, mem_en_toggle}, 64'h1);
        cfg_op(0, 'h70, 0);
        check("R4 set/clear result", cfg_rdata, 64'h0000_0000_0000_0FA0);

        // R3: fault AND/OR aliases, OR reached from mm via index wrap
        cfg_op(1, 'h00, 64'hFF00_FF00_FF00_FF00);
        cfg_op(1, 'h08, 64'h0F0F_0F0F_0F0F_0F0F);
        mm_op(1, 'h7C0, 64'h1);
        cfg_op(0, 'h00, 0);
        check("R3 fault and/or", cfg_rdata, 64'h0F00_0F00_0F00_0F01);

        // R5: mm write to base refused
        mm_op(1, 'h00, 64'h0);
        check("R5 err pulse", {63'b0, access_err}, 64'h1);
        cfg_op(0, 'h50, 0);
        check("R5 base unchanged", cfg_rdata, BASE_RESET | 64'h1);
        // R6: masks
        cfg_op(1, 'h50, ONES);
        cfg_op(0, 'h50, 0);
        check("R6 base mask", cfg_rdata, 64'h0003_FFFF_FFF0_0001);
        cfg_op(1, 'h58, ONES);
        mm_op(0, 'h08, 0);
        check("R6 base2 mask", mm_rdata, 64'h0003_FFFF_0000_0000);

        // R7: unimplemented and write-only indices
        cfg_op(0, 'h18, 0);
        check("R7 hole reads ones", cfg_rdata, ONES);
        cfg_op(0, 'h90, 0);
        check("R7 alias reads ones", cfg_rdata, ONES);
        cfg_op(1, 'h18, 64'h0);
        cfg_op(0, 'h00, 0);
        check("R7 hole write dropped", cfg_rdata, 64'h0F00_0F00_0F00_0F01);

        // R8: status read-only
        cfg_op(1, 'hA8, ONES);
        check("R8 err pulse", {63'b0, access_err}, 64'h1);
        mm_op(0, 'h58, 0);
        check("R8 status zero", mm_rdata, 64'h0);

        // R12: misaligned access
        cfg_op(0, 'h71, 0);
        check("R12 misaligned read", cfg_rdata, ONES);
        cfg_op(1, 'h71, ONES);
        cfg_op(0, 'h70, 0);
        check("R12 misaligned write dropped", cfg_rdata, 64'h0000_0000_0000_0FA0);

        // R9: both ports valid in one cycle
        cfg_valid = 1; cfg_write = 0; cfg_addr = 'h70;
        mm_valid = 1; mm_write = 1; mm_addr = 'h28; mm_wdata = 64'h1234;
        #1;
        check("R9 mm stalled", {63'b0, mm_ready}, 64'h0);
        @(negedge clk);
        cfg_valid = 0;
        check("R9 cfg served first", {63'b0, cfg_rvalid}, 64'h1);
        @(negedge clk);
        mm_valid = 0;
        cfg_op(0, 'h78, 0);
        check("R9 mm write landed", cfg_rdata, 64'h1234);

        // R2: random mixed traffic on both ports, model compared every cycle
        for (int n = 0; n < 600; n++) begin
            int idx;
            idx = $urandom_range(0, 31);
            cfg_valid = ($urandom_range(0, 2) == 0);
            cfg_write = $urandom_range(0, 1);
            cfg_addr  = ADDR_W'(idx * 8 + (($urandom_range(0, 7) == 0) ? 3 : 0));
            cfg_wdata = {$urandom, $urandom};
            idx = $urandom_range(0, 31);
            mm_valid  = ($urandom_range(0, 1) == 0);
            mm_write  = $urandom_range(0, 1);
            mm_addr   = ADDR_W'(((idx + 246) & 255) * 8);
            mm_wdata  = {$urandom, $urandom};
            @(negedge clk);
        end
        cfg_valid = 0; mm_valid = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule